// File: doc/BRIEF.md
# Serial Converter Frame Master

This block is the host side of a link to a serial sampling converter. The converter takes its sample when chip select falls. It returns sixteen bits, paced by a serial clock that the host drives. When the block sees a start request it lowers chip select and waits a set number of system clocks. It then produces sixteen serial clock periods by dividing the system clock. Each incoming bit is taken on the serial clock edge opposite the one that launched it. The framing zeros are stripped, and the conversion result is handed over with a one-cycle valid strobe.

The converter has no power mode register. Its mode follows from how many serial clock falling edges it sees before chip select goes high again. The block gives each command its own chip-select pulse. A sleep command ends the frame early, inside the power-down window. A wake command runs a full frame whose data is thrown away. A read issued while the converter is known to be asleep is treated as that same discarded wake frame. Between frames, chip select is held high for a minimum quiet time. A busy output shows when a start request would be ignored.

The default build returns a 12-bit result. Setting `RES_BITS` to 10 takes the ten bits that follow the leading zeros and drops the two trailing zeros. `SETUP_CYC` and `HALF_CYC` must be at least 2, because the data input passes through one register before it is used.

Top module: `adc_frame_master`

## Requirements
- R1: While reset is held and right after it is released, `cs_n` is high, `sclk` is high, `busy` is low, `sample_valid` is low and `sample_data` is zero.
- R2: A read frame (cmd 2'b00, or 2'b11, which acts as a read) produces exactly 16 falling edges of `sclk` while `cs_n` is low, and never more than 16.
- R3: The first falling edge of `sclk` comes exactly `SETUP_CYC` system clocks after `cs_n` falls.
- R4: Every low phase and every high phase of `sclk` inside a frame lasts exactly `HALF_CYC` system clocks, and `sclk` is high whenever `cs_n` is high.
- R5: Stream bit 0 is present when `cs_n` falls, and bit k (1..15) is launched by falling edge k. Each bit is taken on the next rising edge. With `RES_BITS`=12, `sample_data` is stream bits 4..15, with bit 4 as the MSB.
- R6: `sample_valid` is a single-cycle pulse, raised in the same cycle that `cs_n` rises. It appears only at the end of a complete read frame issued while the converter was awake. `sample_data` holds its value until the next pulse.
- R7: Between two frames `cs_n` stays high for at least `QUIET_CYC` system clocks, even when `start` is held high throughout.
- R8: `busy` is high from the cycle after a start is accepted until the quiet time ends. A `start` seen while `busy` is high starts no frame.
- R9: cmd 2'b01 (sleep) raises `cs_n` one half period after falling edge `PD_EDGES` (default 4, which must lie in 2..9), with no rising edge in between. Every chip-select pulse has either 16 falling edges or a count in 2..9. No `sample_valid` is produced.
- R10: cmd 2'b10 (wake) runs a full 16-edge frame with no `sample_valid`. The next read frame produces a valid sample.
- R11: A read issued after a sleep frame runs as a full 16-edge dummy frame with no `sample_valid`. The read after that produces a valid sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame request, taken only when not busy |
| cmd | input | 2 | 00 read, 01 sleep, 10 wake, 11 read |
| sdata_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles high |
| busy | output | 1 | Frame or quiet time in progress |
| sample_data | output | RES_BITS | Last valid conversion result |
| sample_valid | output | 1 | One-cycle strobe for a new result |

## Verification
The bench models the converter's side of the link. It shifts out a known result, counts the falling edges in each chip-select pulse, and from that count tracks whether the converter is asleep.

The result patterns are all zeros, all ones, alternating bits and a lone MSB. An off-by-one capture would show up as a result shifted by one place, or as a leading zero leaking into the MSB. The bench checks the edge count of the sleep frame, which catches a cut that lands outside the power-down window. It also checks that the frame after a sleep is discarded, which catches a design that reports the invalid dummy data. Finally it holds `start` high across two frames and pulses it in the middle of a frame. A design that skips the quiet time would shorten the gap, and one that re-arms while busy would start a second frame.

// File: rtl/adc_fm_pkg.sv
package adc_fm_pkg;

  localparam int FRAME_BITS = 16;
  localparam int LEAD_ZEROS = 4;

  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_SLEEP = 2'b01,
    CMD_WAKE  = 2'b10,
    CMD_READ2 = 2'b11
  } fm_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_QUIET
  } fm_state_e;

  // Commands whose complete frame carries a usable result.
  function automatic logic cmd_yields_data(input logic [1:0] c);
    return (c == CMD_READ) || (c == CMD_READ2);
  endfunction

  // A rising edge after falling edge n captures a bit only for n below the frame length.
  function automatic logic rise_captures(input int unsigned n);
    return n < FRAME_BITS;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adc_fm_timer.sv
module adc_fm_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_fm_shifter.sv
module adc_fm_shifter
  import adc_fm_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                shift_en,
  input  logic                din,
  input  logic                latch,
  output logic [RES_BITS-1:0] sample_data,
  output logic                sample_valid
);
  localparam int TOP = FRAME_BITS - LEAD_ZEROS - 1;

  logic [FRAME_BITS-1:0] frame_q;
  logic [RES_BITS-1:0]   data_q;
  logic                  valid_q;

  // The result sits just below the leading zeros; trailing zeros fall off the bottom.
  function automatic logic [RES_BITS-1:0] pick_result(input logic [FRAME_BITS-1:0] f);
    return f[TOP -: RES_BITS];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame_q <= '0;
    else if (clear)    frame_q <= '0;
    else if (shift_en) frame_q <= {frame_q[FRAME_BITS-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= latch;
      if (latch) data_q <= pick_result(frame_q);
    end
  end

  assign sample_data  = data_q;
  assign sample_valid = valid_q;
endmodule

// File: rtl/adc_fm_seq.sv
module adc_fm_seq
  import adc_fm_pkg::*;
#(
  parameter int HALF_CYC  = 2,
  parameter int SETUP_CYC = 2,
  parameter int QUIET_CYC = 4,
  parameter int PD_EDGES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] cmd,
  output logic       cs_n,
  output logic       sclk,
  output logic       busy,
  output logic       evt_accept,
  output logic       evt_fall,
  output logic       evt_rise,
  output logic       evt_capture,
  output logic       evt_done,
  output logic       evt_pd_cut,
  output logic       evt_valid
);
  localparam int TMAX = max3(HALF_CYC, SETUP_CYC, QUIET_CYC);
  localparam int TW   = (TMAX < 2) ? 1 : $clog2(TMAX);
  localparam logic [4:0]    FB     = 5'(FRAME_BITS);
  localparam logic [4:0]    PD_N   = 5'(PD_EDGES);
  localparam logic [TW-1:0] T_HALF = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] T_SET  = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] T_QUI  = TW'(QUIET_CYC - 1);

  fm_state_e   state_q, state_d;
  logic        cs_q, sclk_q, asleep_q;
  logic [4:0]  nfall_q;
  logic [1:0]  cmd_q;
  logic        t_load, t_exp;
  logic [TW-1:0] t_val;
  logic        setup_end, low_end, high_end;

  adc_fm_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  always_comb begin
    evt_accept  = (state_q == ST_IDLE) && start;
    setup_end   = (state_q == ST_SETUP) && t_exp;
    low_end     = (state_q == ST_LOW)   && t_exp;
    high_end    = (state_q == ST_HIGH)  && t_exp;
    evt_pd_cut  = low_end && (cmd_q == CMD_SLEEP) && (nfall_q == PD_N);
    evt_fall    = setup_end || (high_end && (nfall_q != FB));
    evt_rise    = low_end && !evt_pd_cut;
    evt_capture = setup_end || (evt_rise && rise_captures(32'(nfall_q)));
    evt_done    = high_end && (nfall_q == FB);
    evt_valid   = evt_done && cmd_yields_data(cmd_q) && !asleep_q;
  end

  always_comb begin
    t_load = evt_accept || evt_fall || evt_rise || evt_pd_cut || evt_done;
    if (evt_accept)                 t_val = T_SET;
    else if (evt_fall || evt_rise)  t_val = T_HALF;
    else                            t_val = T_QUI;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (evt_accept) state_d = ST_SETUP;
      ST_SETUP: if (setup_end)  state_d = ST_LOW;
      ST_LOW:   if (evt_pd_cut) state_d = ST_QUIET;
                else if (low_end) state_d = ST_HIGH;
      ST_HIGH:  if (evt_done)   state_d = ST_QUIET;
                else if (high_end) state_d = ST_LOW;
      ST_QUIET: if (t_exp)      state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      nfall_q  <= '0;
      cmd_q    <= CMD_READ;
      asleep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (evt_accept) begin
        cs_q    <= 1'b0;
        cmd_q   <= cmd;
        nfall_q <= '0;
      end
      if (evt_fall) begin
        sclk_q  <= 1'b0;
        nfall_q <= nfall_q + 5'd1;
      end
      if (evt_rise) sclk_q <= 1'b1;
      if (evt_pd_cut) begin
        cs_q     <= 1'b1;
        sclk_q   <= 1'b1;
        asleep_q <= 1'b1;
      end
      if (evt_done) begin
        cs_q     <= 1'b1;
        asleep_q <= 1'b0;
      end
    end
  end

  assign cs_n = cs_q;
  assign sclk = sclk_q;
  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/adc_frame_master.sv
module adc_frame_master
  import adc_fm_pkg::*;
#(
  parameter int RES_BITS  = 12,
  parameter int HALF_CYC  = 2,
  parameter int SETUP_CYC = 2,
  parameter int QUIET_CYC = 4,
  parameter int PD_EDGES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          cmd,
  input  logic                sdata_in,
  output logic                cs_n,
  output logic                sclk,
  output logic                busy,
  output logic [RES_BITS-1:0] sample_data,
  output logic                sample_valid
);
  logic sdata_q;
  logic evt_accept, evt_fall, evt_rise, evt_capture, evt_done, evt_pd_cut, evt_valid;

  // One register on the pin; SETUP_CYC and HALF_CYC of at least 2 cover its delay.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdata_q <= 1'b0;
    else        sdata_q <= sdata_in;
  end

  adc_fm_seq #(
    .HALF_CYC  (HALF_CYC),
    .SETUP_CYC (SETUP_CYC),
    .QUIET_CYC (QUIET_CYC),
    .PD_EDGES  (PD_EDGES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cmd         (cmd),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .busy        (busy),
    .evt_accept  (evt_accept),
    .evt_fall    (evt_fall),
    .evt_rise    (evt_rise),
    .evt_capture (evt_capture),
    .evt_done    (evt_done),
    .evt_pd_cut  (evt_pd_cut),
    .evt_valid   (evt_valid)
  );

  adc_fm_shifter #(.RES_BITS(RES_BITS)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (evt_accept),
    .shift_en     (evt_capture),
    .din          (sdata_q),
    .latch        (evt_valid),
    .sample_data  (sample_data),
    .sample_valid (sample_valid)
  );
endmodule

// File: rtl/adc_fm_checker.sv
module adc_fm_checker #(
  parameter int QUIET_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic sample_valid
);
  logic [15:0] qcnt;
  logic [5:0]  fcnt;
  logic        sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt   <= 16'(QUIET_CYC);
      fcnt   <= '0;
      sclk_d <= 1'b1;
    end else begin
      sclk_d <= sclk;
      if (!cs_n) qcnt <= '0;
      else if (qcnt < 16'(QUIET_CYC)) qcnt <= qcnt + 16'd1;
      if (cs_n) fcnt <= '0;
      else if (sclk_d && !sclk) fcnt <= fcnt + 6'd1;
    end
  end

  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n) fcnt <= 6'd16);
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk);
  p_valid_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $rose(cs_n));
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  p_quiet_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (qcnt >= 16'(QUIET_CYC)));
  p_busy_frame_r8: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
  p_cut_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ((fcnt == 6'd16) || ((fcnt >= 6'd2) && (fcnt < 6'd10))));
endmodule

bind adc_frame_master adc_fm_checker #(.QUIET_CYC(QUIET_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .sclk         (sclk),
  .busy         (busy),
  .sample_valid (sample_valid)
);

// File: tb/tb_adc_frame_master.sv
module tb_adc_frame_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 2;
  localparam int SETUP = 2;
  localparam int QUIET = 4;
  localparam int PDN   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic sdata_in = 1'b0;
  logic cs_n, sclk, busy, sample_valid;
  logic [11:0] sample_data;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  adc_frame_master dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .sdata_in(sdata_in),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .sample_data(sample_data),
    .sample_valid(sample_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Converter model and monitors
  logic [11:0] adc_val = 12'h000;
  logic [15:0] word;
  int falls_cur = 0, last_falls = 0, cs_falls = 0;
  int cyc = 0, t_fall = -1, t_rise = -1;
  int lo_min, lo_max, hi_min, hi_max;
  int setup_cnt = 0, gap = 0, last_gap = 0;
  int valid_cnt = 0, vrun = 0, vmax = 0;
  logic [11:0] last_data = 12'h000;

  always @(negedge cs_n) begin
    word = {4'b0000, adc_val};
    falls_cur = 0;
    cs_falls++;
    setup_cnt = 0;
    t_rise = -1;
    sdata_in = word[15];
  end

  always @(posedge cs_n) begin
    last_falls = falls_cur;
    sdata_in = 1'b0;
  end

  always @(negedge sclk) begin
    falls_cur++;
    sdata_in = (falls_cur <= 15) ? word[15 - falls_cur] : 1'b0;
    t_fall = cyc;
    if (t_rise >= 0) begin
      if (cyc - t_rise < hi_min) hi_min = cyc - t_rise;
      if (cyc - t_rise > hi_max) hi_max = cyc - t_rise;
    end
  end

  always @(posedge sclk) begin
    if (t_fall >= 0) begin
      if (cyc - t_fall < lo_min) lo_min = cyc - t_fall;
      if (cyc - t_fall > lo_max) lo_max = cyc - t_fall;
    end
    t_rise = cyc;
  end

  always @(negedge clk) begin
    cyc++;
    if (!cs_n && sclk && falls_cur == 0) setup_cnt++;
    if (cs_n) gap++;
    else if (gap != 0) begin
      last_gap = gap;
      gap = 0;
    end
    if (sample_valid) begin
      vrun++;
      if (vrun == 1) begin
        valid_cnt++;
        last_data = sample_data;
      end
      if (vrun > vmax) vmax = vrun;
    end else vrun = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    lo_min = 1000; lo_max = 0; hi_min = 1000; hi_max = 0;
    t_fall = -1; t_rise = -1;
  endtask

  task automatic run_frame(input logic [1:0] c);
    @(negedge clk);
    start = 1'b1;
    cmd = c;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // R2 R3 R4 R5 R6: one read frame on an awake converter
  task automatic t_read(input logic [11:0] v, input logic [1:0] c);
    int v0;
    adc_val = v;
    v0 = valid_cnt;
    clear_stats();
    run_frame(c);
    chk(last_falls == 16, "R2 falls per read frame", last_falls, 16);
    chk(setup_cnt == SETUP, "R3 setup cycles", setup_cnt, SETUP);
    chk(lo_min == HALF && lo_max == HALF, "R4 low phase", lo_max, HALF);
    chk(hi_min == HALF && hi_max == HALF, "R4 high phase", hi_max, HALF);
    chk(valid_cnt == v0 + 1, "R6 valid pulses", valid_cnt - v0, 1);
    chk(vmax == 1, "R6 valid width", vmax, 1);
    chk(last_data == v, "R5 sample value", int'(last_data), int'(v));
    chk(sample_data == v, "R6 data held", int'(sample_data), int'(v));
  endtask

  // R8: a start during a frame is dropped
  task automatic t_ignore_start();
    int f0;
    f0 = cs_falls;
    adc_val = 12'h3C3;
    @(negedge clk); start = 1'b1; cmd = 2'b00;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R8 busy mid frame", busy, 1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(cs_falls == f0 + 1, "R8 frames started", cs_falls - f0, 1);
    chk(cs_n == 1'b1 && busy == 1'b0, "R8 idle after", busy, 0);
  endtask

  // R7: start held high across two frames
  task automatic t_back_to_back();
    int f0, v0;
    f0 = cs_falls;
    v0 = valid_cnt;
    adc_val = 12'h5A5;
    @(negedge clk); start = 1'b1; cmd = 2'b00;
    while (cs_falls < f0 + 2) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk(last_gap >= QUIET, "R7 quiet gap", last_gap, QUIET);
    chk(valid_cnt == v0 + 2, "R7 two samples", valid_cnt - v0, 2);
  endtask

  // R9: sleep cut
  task automatic t_sleep();
    int v0;
    v0 = valid_cnt;
    clear_stats();
    run_frame(2'b01);
    chk(last_falls == PDN, "R9 edges before cut", last_falls, PDN);
    chk(last_falls >= 2 && last_falls < 10, "R9 in window", last_falls, PDN);
    chk(lo_max == HALF, "R9 cut after half period", lo_max, HALF);
    chk(valid_cnt == v0, "R9 no sample", valid_cnt - v0, 0);
  endtask

  // R10 R11: discarded frame then valid read
  task automatic t_dummy(input logic [1:0] c, input string req);
    int v0;
    v0 = valid_cnt;
    adc_val = 12'h777;
    run_frame(c);
    chk(last_falls == 16, {req, " dummy full frame"}, last_falls, 16);
    chk(valid_cnt == v0, {req, " dummy discarded"}, valid_cnt - v0, 0);
    adc_val = 12'h2B4;
    run_frame(2'b00);
    chk(valid_cnt == v0 + 1, {req, " next read valid"}, valid_cnt - v0, 1);
    chk(last_data == 12'h2B4, {req, " next read data"}, int'(last_data), 'h2B4);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1 pins in reset", {cs_n, sclk}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    chk(sclk == 1'b1, "R1 sclk", sclk, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(sample_valid == 1'b0, "R1 valid", sample_valid, 0);
    chk(sample_data == 12'h000, "R1 data", int'(sample_data), 0);

    t_read(12'hA5C, 2'b00);
    t_read(12'h000, 2'b00);
    t_read(12'hFFF, 2'b00);
    t_read(12'h800, 2'b11);
    t_ignore_start();
    t_back_to_back();
    t_sleep();
    t_dummy(2'b00, "R11");
    t_sleep();
    t_dummy(2'b10, "R10");
    t_read(12'h001, 2'b00);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule